// File: doc/BRIEF.md
# Receive Message Queue Bookkeeper

This block keeps the books for a receive queue that holds whole bus messages. Each time the frame receiver finishes a message, it raises a completion pulse together with the message length in bytes. The bookkeeper checks whether the queue has room for that many bytes and for one more message entry. If it has room, the message is counted as stored. If not, the message is dropped and a sticky overrun condition is raised. Software frees the oldest stored message one at a time with a release command, and it clears the overrun condition with a separate command.

Byte occupancy is tracked against a configurable capacity. An internal queue remembers the length of every stored message in arrival order, so that a release gives back exactly the bytes of the oldest message. The block does not include the message RAM or the frame decoder. While the controller is held in its reset mode, completed receptions are treated as aborted and are not recorded.

Top module: `rx_msg_book`

## Requirements
- R1: `msg_count_o` (7 bits) rises by one one cycle after a stored message and falls by one one cycle after an honoured release.
- R2: `buf_full_o` is 1 exactly when `msg_count_o` is non-zero.
- R3: A completed message is stored only if its length is no more than the capacity minus the current byte occupancy, and fewer than `MSG_DEPTH` messages are held. Otherwise the message is dropped and `overrun_o` is 1 from the next cycle.
- R4: Once set, `overrun_o` stays at 1 until a cycle with `clr_ovr_i` high and no drop. A drop in the same cycle as a clear leaves it set.
- R5: On each completed message accepted outside reset mode, `miss_o` becomes 1 if the message was dropped and 0 if it was stored. Otherwise `miss_o` holds.
- R6: `overrun_irq_o` is high for exactly one cycle: the first cycle in which `overrun_o` reads 1 after having read 0.
- R7: A release while `msg_count_o` is 0 has no effect on any output.
- R8: A store and an honoured release in the same cycle leave `msg_count_o` unchanged. Occupancy becomes the old value plus the new length minus the oldest length, and the room check for the new message uses the occupancy held before the release.
- R9: While `reset_mode_i` is high, completion pulses are ignored: no count change, no overrun and no change of `miss_o`. Releases and overrun clears still act.
- R10: A release frees the byte length of the oldest stored message, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_mode_i | input | 1 | Controller reset mode; receptions are aborted |
| msg_done_i | input | 1 | One-cycle pulse: a message has completed |
| msg_len_i | input | LEN_W | Byte length of the completed message |
| release_i | input | 1 | Release the oldest stored message |
| clr_ovr_i | input | 1 | Clear the overrun status |
| msg_count_o | output | 7 | Number of stored messages |
| buf_full_o | output | 1 | One or more messages are available |
| overrun_o | output | 1 | Sticky overrun status |
| miss_o | output | 1 | The most recent completed message was dropped |
| overrun_irq_o | output | 1 | Pulse on each rising edge of overrun |

## Verification
Every output is registered. A completion, release or clear presented before clock edge N shows up on the count, status, miss and pulse outputs after edge N. The one-cycle overrun pulse coincides with the first cycle in which `overrun_o` reads 1.

The bench drives its inputs on the falling edge. It advances a behavioural queue model at the rising edge and compares all five outputs at the following falling edge, so every comparison falls in the single cycle in which that result is due.

Directed phases cover:
- filling to the byte limit,
- filling to the message-count limit,
- clear and drop in the same cycle,
- store and release in the same cycle,
- release of an empty queue,
- reset mode.

A long random phase follows.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Width of the message counter seen by software
    localparam int CNT_W = 7;

    // Per-cycle decision taken by the occupancy tracker
    typedef struct packed {
        logic store;   // completed message accepted into the queue
        logic drop;    // completed message discarded for lack of room
        logic pop;     // oldest message released
    } rxq_evt_t;

    function automatic logic [CNT_W-1:0] rxq_step_count(
        input logic [CNT_W-1:0] cur,
        input logic             inc,
        input logic             dec
    );
        logic [CNT_W-1:0] res;
        unique case ({inc, dec})
            2'b10:   res = cur + 1'b1;
            2'b01:   res = cur - 1'b1;
            default: res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/rxq_len_fifo.sv
module rxq_len_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_len,
    input  logic         pop,
    output logic [W-1:0] head_len
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr, wptr_nx, rptr_nx;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            // pointers wrap naturally
            assign wptr_nx = wptr + 1'b1;
            assign rptr_nx = rptr + 1'b1;
        end else begin : g_wrap
            assign wptr_nx = (wptr == LAST) ? '0 : wptr + 1'b1;
            assign rptr_nx = (rptr == LAST) ? '0 : rptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr_nx;
            if (pop)  rptr <= rptr_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_len;
    end

    assign head_len = mem[rptr];

endmodule

// File: rtl/rxq_occ.sv
module rxq_occ
    import rxq_pkg::*;
#(
    parameter int CAP_BYTES = 64,
    parameter int LEN_W     = 4,
    parameter int MSG_DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic [LEN_W-1:0] len,
    input  logic             abort,
    input  logic             release_req,
    input  logic [LEN_W-1:0] head_len,
    output rxq_evt_t         evt,
    output logic [CNT_W-1:0] count
);
    localparam int OCC_W = $clog2(CAP_BYTES + 1);
    localparam int SUM_W = ((OCC_W > LEN_W) ? OCC_W : LEN_W) + 1;
    localparam logic [SUM_W-1:0] CAP_S   = SUM_W'(CAP_BYTES);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(MSG_DEPTH);

    logic [OCC_W-1:0] occ;
    logic [SUM_W-1:0] free_s, len_s, occ_nx;
    logic             fits, accept;

    assign free_s = CAP_S - SUM_W'(occ);
    assign len_s  = SUM_W'(len);
    assign fits   = (len_s <= free_s) && (count < DEPTH_C);
    assign accept = done && !abort;

    always_comb begin
        evt.store = accept && fits;
        evt.drop  = accept && !fits;
        evt.pop   = release_req && (count != '0);
        occ_nx    = SUM_W'(occ);
        if (evt.store) occ_nx = occ_nx + len_s;
        if (evt.pop)   occ_nx = occ_nx - SUM_W'(head_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ   <= '0;
            count <= '0;
        end else begin
            occ   <= occ_nx[OCC_W-1:0];
            count <= rxq_step_count(count, evt.store, evt.pop);
        end
    end

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rxq_evt_t evt,
    input  logic     clr,
    output logic     ovr,
    output logic     miss,
    output logic     irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ovr  <= 1'b0;
            miss <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (evt.drop)  ovr <= 1'b1;
            else if (clr)  ovr <= 1'b0;
            irq <= evt.drop && !ovr;
            if (evt.store || evt.drop) miss <= evt.drop;
        end
    end
endmodule

// File: rtl/rx_msg_book.sv
module rx_msg_book
    import rxq_pkg::*;
#(
    parameter int CAP_BYTES = 64,
    parameter int LEN_W     = 4,
    parameter int MSG_DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reset_mode_i,
    input  logic             msg_done_i,
    input  logic [LEN_W-1:0] msg_len_i,
    input  logic             release_i,
    input  logic             clr_ovr_i,
    output logic [CNT_W-1:0] msg_count_o,
    output logic             buf_full_o,
    output logic             overrun_o,
    output logic             miss_o,
    output logic             overrun_irq_o
);
    rxq_evt_t         evt;
    logic [LEN_W-1:0] head_len;

    rxq_len_fifo #(.DEPTH(MSG_DEPTH), .W(LEN_W)) u_lenq (
        .clk      (clk),
        .rst      (rst),
        .push     (evt.store),
        .push_len (msg_len_i),
        .pop      (evt.pop),
        .head_len (head_len)
    );

    rxq_occ #(.CAP_BYTES(CAP_BYTES), .LEN_W(LEN_W), .MSG_DEPTH(MSG_DEPTH)) u_occ (
        .clk         (clk),
        .rst         (rst),
        .done        (msg_done_i),
        .len         (msg_len_i),
        .abort       (reset_mode_i),
        .release_req (release_i),
        .head_len    (head_len),
        .evt         (evt),
        .count       (msg_count_o)
    );

    rxq_flags u_flags (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .clr  (clr_ovr_i),
        .ovr  (overrun_o),
        .miss (miss_o),
        .irq  (overrun_irq_o)
    );

    assign buf_full_o = (msg_count_o != '0);

endmodule

// File: rtl/rx_msg_book_chk.sv
module rx_msg_book_chk #(
    parameter int MSG_DEPTH = 32
) (
    input logic       clk,
    input logic       rst,
    input logic       reset_mode_i,
    input logic       msg_done_i,
    input logic       release_i,
    input logic       clr_ovr_i,
    input logic [6:0] msg_count_o,
    input logic       buf_full_o,
    input logic       overrun_o,
    input logic       miss_o,
    input logic       overrun_irq_o
);
    // R1: count moves by at most one per cycle and never exceeds the depth
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (msg_count_o == $past(msg_count_o)) ||
        (msg_count_o == $past(msg_count_o) + 7'd1) ||
        (msg_count_o == $past(msg_count_o) - 7'd1));
    a_r3_bound: assert property (@(posedge clk) disable iff (rst)
        msg_count_o <= 7'(MSG_DEPTH));
    // R4: overrun is sticky without a clear
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun_o && !clr_ovr_i |=> overrun_o);
    // R6: pulse only on the first cycle of overrun
    a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
        overrun_irq_o |-> overrun_o && !$past(overrun_o));
    // R7: release on empty queue with no arrival keeps count at zero
    a_r7_empty_rel: assert property (@(posedge clk) disable iff (rst)
        (msg_count_o == 7'd0) && release_i && !msg_done_i |=> msg_count_o == 7'd0);
    // R9: reset mode freezes count and miss when nothing is released
    a_r9_abort: assert property (@(posedge clk) disable iff (rst)
        reset_mode_i && !release_i |=> $stable(msg_count_o) && $stable(miss_o));
    a_r9_no_ovr: assert property (@(posedge clk) disable iff (rst)
        reset_mode_i && !overrun_o |=> !overrun_o);
    // R2: status follows count
    a_r2_full: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full_o) |-> $past(msg_count_o) == 7'd0);
endmodule

bind rx_msg_book rx_msg_book_chk #(.MSG_DEPTH(MSG_DEPTH)) u_chk (.*);

// File: tb/rx_msg_book_test.sv
`timescale 1ns/1ps
module rx_msg_book_test;
    localparam int CAP   = 64;
    localparam int LW    = 4;
    localparam int DEPTH = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rm = 1'b0, done = 1'b0, rel = 1'b0, clr = 1'b0;
    logic [LW-1:0] len = '0;
    logic [6:0]    cnt_o;
    logic          full_o, ovr_o, miss_o, irq_o;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    // reference model state
    int q[$];
    int m_occ = 0, m_cnt = 0;
    bit m_ovr = 0, m_miss = 0, m_irq = 0;

    always #10 clk = ~clk;

    rx_msg_book #(.CAP_BYTES(CAP), .LEN_W(LW), .MSG_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .reset_mode_i(rm), .msg_done_i(done),
        .msg_len_i(len), .release_i(rel), .clr_ovr_i(clr),
        .msg_count_o(cnt_o), .buf_full_o(full_o), .overrun_o(ovr_o),
        .miss_o(miss_o), .overrun_irq_o(irq_o));

    task automatic chk(input string req, input string ph, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s]: actual %0d expected %0d", req, ph, act, exp);
        end
    endtask

    task automatic compare(input string ph);
        chk("R1 count",   ph, int'(cnt_o),  m_cnt);
        chk("R2 full",    ph, int'(full_o), int'(m_cnt != 0));
        chk("R3/R4 ovr",  ph, int'(ovr_o),  int'(m_ovr));
        chk("R5 miss",    ph, int'(miss_o), int'(m_miss));
        chk("R6 irq",     ph, int'(irq_o),  int'(m_irq));
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit d, input int l, input bit r, input bit c, input bit mode, input string ph);
        bit st, dr, pp, prev;
        done = d; len = LW'(l); rel = r; clr = c; rm = mode;
        @(posedge clk);
        st = d && !mode && (l <= CAP - m_occ) && (m_cnt < DEPTH);
        dr = d && !mode && !st;
        pp = r && (m_cnt > 0);
        if (pp) begin m_occ -= q.pop_front(); m_cnt--; end
        if (st) begin q.push_back(l); m_occ += l; m_cnt++; end
        prev = m_ovr;
        if (dr) m_ovr = 1; else if (c) m_ovr = 0;
        m_irq = m_ovr && !prev;
        if (st || dr) m_miss = dr;
        @(negedge clk);
        compare(ph);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("reset state");
        // R3: fill by bytes: 4 x 13 + 12 = 64
        for (int i = 0; i < 4; i++) step(1, 13, 0, 0, 0, "R3 fill");
        step(1, 12, 0, 0, 0, "R3 exact fit");
        step(1, 1, 0, 0, 0, "R3 no room drop");
        step(1, 0, 0, 0, 0, "R5 zero length stored");
        step(1, 2, 0, 0, 0, "R6 second drop no pulse");
        step(0, 0, 0, 0, 0, "R4 sticky");
        step(1, 5, 0, 1, 0, "R4 drop beats clear");
        step(0, 0, 0, 1, 0, "R4 clear");
        // R10: release frees 13 (oldest), then 13 fits but 14 not
        step(0, 0, 1, 0, 0, "R10 release oldest");
        step(1, 14, 0, 0, 0, "R10 too big after release");
        step(1, 13, 0, 1, 0, "R10 freed bytes reused");
        // R8: full queue, store + release same cycle uses old occupancy
        step(1, 1, 1, 1, 0, "R8 same cycle no room");
        step(1, 13, 1, 1, 0, "R8 same cycle swap");
        step(1, 13, 0, 0, 0, "R8 occupancy after swap");
        // drain and R7
        for (int i = 0; i < 8; i++) step(0, 0, 1, 1, 0, "R1 drain");
        step(0, 0, 1, 0, 0, "R7 release empty");
        step(0, 0, 1, 0, 0, "R7 release empty again");
        // R9: reset mode ignores completions, release works
        step(1, 3, 0, 0, 0, "R9 prep");
        step(1, 3, 0, 0, 1, "R9 ignored");
        step(1, 15, 0, 0, 1, "R9 ignored big");
        step(0, 0, 1, 0, 1, "R9 release in mode");
        // R3: message-count limit with zero-length messages
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 1, 0, "R3 count fill");
        step(1, 0, 0, 0, 0, "R3 depth drop");
        step(1, 0, 1, 0, 0, "R8 swap at depth");
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, 1, 0, "R1 drain");
        // random traffic
        for (int i = 0; i < 3000; i++)
            step(($urandom % 3) != 0, $urandom % 16, ($urandom % 3) == 0,
                 ($urandom % 8) == 0, ($urandom % 16) == 0, "random");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule